// File: doc/BRIEF.md
# Rotating Task Context Ring

This block keeps one complete set of processor registers for every task that a small multitasking core runs. The sets sit in a circular chain. The set in the first position is the working register set. The processor reads it directly and updates it field by field through load enables. The processor does not need to know which task owns that working set, because the ring alone decides which context sits there.

A scheduler asks for a switch by giving a target task number. The ring then moves every context one position per clock until the target's context reaches the working position, and it pulses a done flag. A move to the next task in ring order costs one clock. A move across `d` positions costs `d` clocks. The saved fields are an accumulator, an index register, a condition-code register, a stack pointer and a program counter. Each field width and the task count are parameters.

Top module: `taskCtxRing`

## Requirements
- R1: After reset every saved field of every task is zero, `curTask` is 0, and `swBusy` and `swDone` are low.
- R2: In a cycle with no rotation, each field whose load enable is high takes its input value at the clock edge and shows it on its output from the next cycle. Fields whose load enable is low keep their value.
- R3: An accepted request whose target is `curTask+1` modulo `NUM_TASKS` rotates once. `curTask` and the working set change at the next edge, and `swDone` is high in the cycle after the request.
- R4: An accepted request rotates exactly `d = (target - curTask) mod NUM_TASKS` times, one per clock. `curTask` increments modulo `NUM_TASKS` on each rotation. `swBusy` is high in the `d-1` cycles between the request and completion. `swDone` goes high after the `d`-th edge.
- R5: An accepted request whose target equals `curTask` causes no rotation. `swDone` is high in the following cycle and `swBusy` stays low.
- R6: A task's saved fields are kept unchanged while other tasks are active. Switching back shows the values it last held.
- R7: Processor loads are dropped in any cycle in which the ring rotates, including the cycle in which a request is accepted with `d > 0`. A load and a request with `d = 0` in the same cycle is applied.
- R8: A request is accepted only when `swBusy` is low. A request made while `swBusy` is high has no effect on the switch in progress.
- R9: A request whose target is `NUM_TASKS` or more is ignored. There is no rotation, no `swBusy` and no `swDone`.
- R10: `swDone` is high for exactly one cycle per completed switch, and is never high together with `swBusy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accLd | input | 1 | Load enable for the accumulator |
| accIn | input | ACC_W | New accumulator value |
| idxLd | input | 1 | Load enable for the index register |
| idxIn | input | IDX_W | New index value |
| ccrLd | input | 1 | Load enable for the condition codes |
| ccrIn | input | CCR_W | New condition-code value |
| spLd | input | 1 | Load enable for the stack pointer |
| spIn | input | SP_W | New stack pointer value |
| pcLd | input | 1 | Load enable for the program counter |
| pcIn | input | PC_W | New program counter value |
| accOut | output | ACC_W | Working accumulator |
| idxOut | output | IDX_W | Working index register |
| ccrOut | output | CCR_W | Working condition codes |
| spOut | output | SP_W | Working stack pointer |
| pcOut | output | PC_W | Working program counter |
| swReq | input | 1 | Switch request strobe |
| swTarget | input | ID_W | Task number to switch to |
| swBusy | output | 1 | A multi-step switch is in progress |
| swDone | output | 1 | One-cycle pulse when a switch completes |
| curTask | output | ID_W | Task whose context is in the working set |

## Verification
The bench builds the ring with seven tasks and the default field widths of 8, 8, 5, 5 and 12 bits. Seven tasks give a three-bit task number. This reaches the six-step worst-case switch from task 0 to task 6 and wrap-around switches such as 5 to 1. It also leaves the single unused code 7, which exercises the rejection of out-of-range targets. The random mix of loads, same-task requests, requests made while busy and loads during rotation checks that each task's context survives the other tasks' activity.

// File: rtl/taskCtxPkg.sv
package taskCtxPkg;
  typedef struct packed {
    logic rotate;
    logic wrEn;
  } ctxStrobe_t;
endpackage

// File: rtl/taskCtxCtrl.sv
module taskCtxCtrl
  import taskCtxPkg::*;
#(
  parameter int NUM_TASKS = 7,
  parameter int ID_W = $clog2(NUM_TASKS)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            swReq,
  input  logic [ID_W-1:0] swTarget,
  output logic            swBusy,
  output logic            swDone,
  output logic [ID_W-1:0] curTask,
  output ctxStrobe_t      stb
);
  localparam logic [ID_W-1:0] LAST_ID = ID_W'(NUM_TASKS - 1);

  logic [ID_W-1:0] tgtReg, tgtEff, nextCur;
  logic accept, active, rotate;

  always_comb begin
    accept  = swReq && !swBusy && (swTarget <= LAST_ID);
    active  = swBusy || accept;
    tgtEff  = swBusy ? tgtReg : swTarget;
    rotate  = active && (curTask != tgtEff);
    nextCur = curTask;
    if (rotate) nextCur = (curTask == LAST_ID) ? '0 : curTask + 1'b1;
    stb.rotate = rotate;
    stb.wrEn   = !rotate;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curTask <= '0;
      tgtReg  <= '0;
      swBusy  <= 1'b0;
      swDone  <= 1'b0;
    end else begin
      curTask <= nextCur;
      swDone  <= 1'b0;
      if (active) begin
        tgtReg <= tgtEff;
        if (nextCur == tgtEff) begin
          swBusy <= 1'b0;
          swDone <= 1'b1;
        end else begin
          swBusy <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/taskCtxStore.sv
module taskCtxStore
  import taskCtxPkg::*;
#(
  parameter int NUM_TASKS = 7,
  parameter int ACC_W = 8,
  parameter int IDX_W = 8,
  parameter int CCR_W = 5,
  parameter int SP_W  = 5,
  parameter int PC_W  = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctxStrobe_t       stb,
  input  logic             accLd,
  input  logic [ACC_W-1:0] accIn,
  input  logic             idxLd,
  input  logic [IDX_W-1:0] idxIn,
  input  logic             ccrLd,
  input  logic [CCR_W-1:0] ccrIn,
  input  logic             spLd,
  input  logic [SP_W-1:0]  spIn,
  input  logic             pcLd,
  input  logic [PC_W-1:0]  pcIn,
  output logic [ACC_W-1:0] accOut,
  output logic [IDX_W-1:0] idxOut,
  output logic [CCR_W-1:0] ccrOut,
  output logic [SP_W-1:0]  spOut,
  output logic [PC_W-1:0]  pcOut
);
  localparam int OFF_ACC = 0;
  localparam int OFF_IDX = OFF_ACC + ACC_W;
  localparam int OFF_CCR = OFF_IDX + IDX_W;
  localparam int OFF_SP  = OFF_CCR + CCR_W;
  localparam int OFF_PC  = OFF_SP + SP_W;
  localparam int CTX_W   = OFF_PC + PC_W;

  logic [CTX_W-1:0] ring [NUM_TASKS];
  logic [CTX_W-1:0] wrWord;

  always_comb begin
    wrWord = ring[0];
    if (accLd) wrWord[OFF_ACC +: ACC_W] = accIn;
    if (idxLd) wrWord[OFF_IDX +: IDX_W] = idxIn;
    if (ccrLd) wrWord[OFF_CCR +: CCR_W] = ccrIn;
    if (spLd)  wrWord[OFF_SP  +: SP_W]  = spIn;
    if (pcLd)  wrWord[OFF_PC  +: PC_W]  = pcIn;
  end

  for (genvar i = 0; i < NUM_TASKS; i++) begin : g_slot
    localparam int NXT = (i + 1) % NUM_TASKS;
    if (i == 0) begin : g_work
      always_ff @(posedge clk) begin
        if (!rstN)           ring[i] <= '0;
        else if (stb.rotate) ring[i] <= ring[NXT];
        else if (stb.wrEn)   ring[i] <= wrWord;
      end
    end else begin : g_hold
      always_ff @(posedge clk) begin
        if (!rstN)           ring[i] <= '0;
        else if (stb.rotate) ring[i] <= ring[NXT];
      end
    end
  end

  assign accOut = ring[0][OFF_ACC +: ACC_W];
  assign idxOut = ring[0][OFF_IDX +: IDX_W];
  assign ccrOut = ring[0][OFF_CCR +: CCR_W];
  assign spOut  = ring[0][OFF_SP  +: SP_W];
  assign pcOut  = ring[0][OFF_PC  +: PC_W];
endmodule

// File: rtl/taskCtxRing.sv
module taskCtxRing
  import taskCtxPkg::*;
#(
  parameter int NUM_TASKS = 7,
  parameter int ACC_W = 8,
  parameter int IDX_W = 8,
  parameter int CCR_W = 5,
  parameter int SP_W  = 5,
  parameter int PC_W  = 12,
  localparam int ID_W = $clog2(NUM_TASKS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             accLd,
  input  logic [ACC_W-1:0] accIn,
  input  logic             idxLd,
  input  logic [IDX_W-1:0] idxIn,
  input  logic             ccrLd,
  input  logic [CCR_W-1:0] ccrIn,
  input  logic             spLd,
  input  logic [SP_W-1:0]  spIn,
  input  logic             pcLd,
  input  logic [PC_W-1:0]  pcIn,
  output logic [ACC_W-1:0] accOut,
  output logic [IDX_W-1:0] idxOut,
  output logic [CCR_W-1:0] ccrOut,
  output logic [SP_W-1:0]  spOut,
  output logic [PC_W-1:0]  pcOut,
  input  logic             swReq,
  input  logic [ID_W-1:0]  swTarget,
  output logic             swBusy,
  output logic             swDone,
  output logic [ID_W-1:0]  curTask
);
  ctxStrobe_t stb;

  taskCtxCtrl #(.NUM_TASKS(NUM_TASKS), .ID_W(ID_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .swReq(swReq), .swTarget(swTarget),
    .swBusy(swBusy), .swDone(swDone), .curTask(curTask), .stb(stb)
  );

  taskCtxStore #(
    .NUM_TASKS(NUM_TASKS), .ACC_W(ACC_W), .IDX_W(IDX_W),
    .CCR_W(CCR_W), .SP_W(SP_W), .PC_W(PC_W)
  ) u_store (
    .clk(clk), .rstN(rstN), .stb(stb),
    .accLd(accLd), .accIn(accIn), .idxLd(idxLd), .idxIn(idxIn),
    .ccrLd(ccrLd), .ccrIn(ccrIn), .spLd(spLd), .spIn(spIn),
    .pcLd(pcLd), .pcIn(pcIn),
    .accOut(accOut), .idxOut(idxOut), .ccrOut(ccrOut),
    .spOut(spOut), .pcOut(pcOut)
  );
endmodule

// File: rtl/taskCtxChk.sv
module taskCtxChk #(
  parameter int NUM_TASKS = 7,
  parameter int ID_W = 3,
  parameter int ACC_W = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             swReq,
  input logic [ID_W-1:0]  swTarget,
  input logic             swBusy,
  input logic             swDone,
  input logic [ID_W-1:0]  curTask,
  input logic             accLd,
  input logic [ACC_W-1:0] accOut
);
  localparam logic [ID_W-1:0] LAST_ID = ID_W'(NUM_TASKS - 1);

  // R4: task number stays within range
  p_id_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    curTask <= LAST_ID);

  // R4: task number only steps forward by one, wrapping at the top
  p_id_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(curTask) |->
      curTask == (($past(curTask) == LAST_ID) ? '0 : $past(curTask) + 1'b1));

  // R4: a busy cycle always moves the ring
  p_busy_moves_r4: assert property (@(posedge clk) disable iff (!rstN)
    swBusy |=> !$stable(curTask));

  // R10: done and busy are exclusive
  p_done_excl_r10: assert property (@(posedge clk) disable iff (!rstN)
    !(swBusy && swDone));

  // R2: with no load and no switch activity the working accumulator holds
  p_acc_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!accLd && !swBusy && !swReq) |=> $stable(accOut));

  // R9: an out-of-range request in idle starts nothing
  p_bad_target_r9: assert property (@(posedge clk) disable iff (!rstN)
    (swReq && !swBusy && swTarget > LAST_ID) |=> (!swBusy && !swDone));
endmodule

bind taskCtxRing taskCtxChk #(.NUM_TASKS(NUM_TASKS), .ID_W(ID_W), .ACC_W(ACC_W)) u_chk (
  .clk(clk), .rstN(rstN), .swReq(swReq), .swTarget(swTarget),
  .swBusy(swBusy), .swDone(swDone), .curTask(curTask),
  .accLd(accLd), .accOut(accOut)
);

// File: tb/test_taskCtxRing.sv
module test_taskCtxRing;
  localparam int CLK_PERIOD = 10;
  localparam int N = 7;
  localparam int IDW = 3;

  logic clk = 1'b0, rstN = 1'b0;
  logic accLd = 0, idxLd = 0, ccrLd = 0, spLd = 0, pcLd = 0;
  logic [7:0] accIn = 0, idxIn = 0;
  logic [4:0] ccrIn = 0, spIn = 0;
  logic [11:0] pcIn = 0;
  logic [7:0] accOut, idxOut;
  logic [4:0] ccrOut, spOut;
  logic [11:0] pcOut;
  logic swReq = 0;
  logic [IDW-1:0] swTarget = 0;
  logic swBusy, swDone;
  logic [IDW-1:0] curTask;

  int total = 0, bad = 0;
  logic [37:0] model [N];
  int curExp = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  taskCtxRing #(.NUM_TASKS(N)) i_taskCtxRing (.*);

  function automatic logic [37:0] packOut();
    return {pcOut, spOut, ccrOut, idxOut, accOut};
  endfunction

  function automatic logic [37:0] merge(logic [37:0] old, logic [4:0] m,
      logic [7:0] a, logic [7:0] x, logic [4:0] c, logic [4:0] s, logic [11:0] p);
    logic [37:0] r = old;
    if (m[0]) r[7:0]   = a;
    if (m[1]) r[15:8]  = x;
    if (m[2]) r[20:16] = c;
    if (m[3]) r[25:21] = s;
    if (m[4]) r[37:26] = p;
    return r;
  endfunction

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic driveLoad(logic [4:0] m, logic [7:0] a, logic [7:0] x,
      logic [4:0] c, logic [4:0] s, logic [11:0] p);
    {pcLd, spLd, ccrLd, idxLd, accLd} = m;
    accIn = a; idxIn = x; ccrIn = c; spIn = s; pcIn = p;
  endtask

  task automatic clearLoad();
    {pcLd, spLd, ccrLd, idxLd, accLd} = '0;
  endtask

  task automatic checkCtx(string req);
    chk(packOut() == model[curExp], req, packOut(), model[curExp]);
    chk(curTask == IDW'(curExp), req, curTask, curExp);
  endtask

  // processor load with no switch activity
  task automatic doLoad(logic [4:0] m);
    logic [7:0] a = 8'($urandom); logic [7:0] x = 8'($urandom);
    logic [4:0] c = 5'($urandom); logic [4:0] s = 5'($urandom);
    logic [11:0] p = 12'($urandom);
    driveLoad(m, a, x, c, s, p);
    @(negedge clk);
    clearLoad();
    model[curExp] = merge(model[curExp], m, a, x, c, s, p);
    checkCtx("R2");
  endtask

  // switch with optional load on the request cycle and disturbance while busy
  task automatic doSwitch(int tgt, bit ldAtReq, bit disturb);
    int d = (tgt - curExp + N) % N;
    int want = (d == 0) ? 1 : d;
    int seen = 0;
    logic [4:0] m = 5'($urandom);
    logic [7:0] a = 8'($urandom); logic [7:0] x = 8'($urandom);
    logic [4:0] c = 5'($urandom); logic [4:0] s = 5'($urandom);
    logic [11:0] p = 12'($urandom);
    swReq = 1'b1; swTarget = IDW'(tgt);
    if (ldAtReq) driveLoad(m, a, x, c, s, p);
    @(negedge clk);
    swReq = 1'b0; clearLoad();
    if (ldAtReq && d == 0) model[curExp] = merge(model[curExp], m, a, x, c, s, p);
    for (int k = 1; k <= N + 1; k++) begin
      if (swDone) begin seen = k; break; end
      chk(swBusy == 1'b1, "R4", swBusy, 1);
      chk(curTask == IDW'((curExp + k) % N), "R4", curTask, (curExp + k) % N);
      if (disturb) begin
        swReq = 1'b1; swTarget = IDW'((tgt + 3) % N);
        driveLoad(5'h1F, 8'($urandom), 8'($urandom), 5'($urandom), 5'($urandom), 12'($urandom));
      end
      @(negedge clk);
      swReq = 1'b0; clearLoad();
    end
    chk(seen == want, d == 0 ? "R5" : (d == 1 ? "R3" : "R4"), seen, want);
    curExp = tgt;
    checkCtx(ldAtReq ? "R7" : "R6");
    chk(swBusy == 1'b0, "R10", swBusy, 0);
    @(negedge clk);
    chk(swDone == 1'b0, "R10", swDone, 0);
    checkCtx(disturb ? "R8" : "R6");
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < N; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    chk(packOut() == '0, "R1", packOut(), 0);
    chk(curTask == '0, "R1", curTask, 0);
    chk(!swBusy && !swDone, "R1", {swBusy, swDone}, 0);
    // R2 single-field loads
    doLoad(5'b00001); doLoad(5'b10000); doLoad(5'b11111);
    // R3 next task, R4 worst case 0 -> 6 path via wrap
    doSwitch(1, 0, 0);
    doLoad(5'b11111);
    doSwitch(0, 0, 0);
    doSwitch(6, 0, 0);
    doLoad(5'b01010);
    // R4 wrap 6 -> 2
    doSwitch(2, 0, 0);
    // R5 same task with a load on the request cycle
    doSwitch(2, 1, 0);
    // R7 load dropped on a moving request, R8 request while busy ignored
    doSwitch(5, 1, 1);
    // R9 out-of-range target
    swReq = 1'b1; swTarget = 3'd7;
    @(negedge clk);
    swReq = 1'b0;
    chk(!swBusy && !swDone, "R9", {swBusy, swDone}, 0);
    @(negedge clk);
    chk(!swDone, "R9", swDone, 0);
    checkCtx("R9");
    // random mix
    for (int it = 0; it < 300; it++) begin
      if ($urandom_range(0, 1) == 0) doLoad(5'($urandom));
      else doSwitch(int'($urandom_range(0, N - 1)), bit'($urandom_range(0, 1)),
                    bit'($urandom_range(0, 1)));
    end
    // R6 visit every task once more
    for (int t = 0; t < N; t++) doSwitch(t, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule